// File: doc/BRIEF.md
# Verified Core Window Selector

This block lets a host reach any one of several equally sized cores on a backplane through a single movable address window. Every access request names a target core, an access size, a direction, an offset inside the core and write data. If the target is already mapped, the access goes straight to the memory port. Otherwise the block first moves the window.

To move the window, the block writes a window base value through a configuration-register port. It then reads the register back and turns the readback into a core index. If the index does not match the target, it waits a fixed time and tries again, up to a bounded number of attempts. Only a confirmed match records the new mapping.

A switch that fails gives the requester an error. A failed read returns all-ones at its access size, and a failed write never reaches the memory port. One request is handled at a time. A busy flag holds off new requests until the response has been given.

Top module: `core_window_ctrl`

## Requirements
- R1: A switch to core `c` writes the window value `ENUM_BASE + (c << REGION_SHIFT)` (defaults: base 0x1800_0000, shift 12) with `cfg_we_o=1`, and holds it until `cfg_ack_i`.
- R2: Each accepted window write is followed by a readback (`cfg_we_o=0`). The readback decodes to `(rdata - ENUM_BASE) >> REGION_SHIFT`, and the switch succeeds only when this equals the target index.
- R3: On a mismatch the block waits `CLK_MHZ*WAIT_US` cycles (default 1000) before writing again. After `MAX_RETRIES+2` mismatching attempts in total (default 5), it fails the request with `resp_err_o=1`.
- R4: A configuration access acknowledged with `cfg_err_i=1` ends the switch at once with an error, and no further configuration access is made for that request.
- R5: After a successful switch, `mapped_valid_o=1` and `mapped_core_o` shows the target. A later request to the same core makes no configuration access.
- R6: After the target is mapped, one memory access is issued with the request's offset, size code, direction and write data. A read responds with `mem_rdata_i` masked to the access size (size code 0 = 8-bit, 1 = 16-bit, 2 = 32-bit). A write responds with zero data and no error.
- R7: If a switch fails, the response carries `resp_err_o=1` and `resp_rdata_o` equal to 0xFF, 0xFFFF or 0xFFFFFFFF for size code 0, 1 or 2, and no memory access is made, so a failed write is dropped.
- R8: `busy_o` is high from the cycle after a request is accepted until its single-cycle `resp_done_o`. Requests presented while busy are ignored.
- R9: After reset, `busy_o=0`, `mapped_valid_o=0` and no configuration or memory request is active.
- R10: A failed switch clears `mapped_valid_o`, so the next request to any core switches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken when not busy |
| req_core_i | input | CORE_W | Target core index |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Access size code: 0 = 8, 1 = 16, 2 = 32 bit |
| req_offset_i | input | OFF_W | Offset inside the core region |
| req_wdata_i | input | 32 | Write data |
| busy_o | output | 1 | Request in progress |
| resp_done_o | output | 1 | One-cycle response strobe |
| resp_err_o | output | 1 | Response error (switch failed) |
| resp_rdata_o | output | 32 | Response read data |
| mapped_valid_o | output | 1 | A core is currently mapped |
| mapped_core_o | output | CORE_W | Index of the mapped core |
| cfg_req_o | output | 1 | Configuration access request |
| cfg_we_o | output | 1 | Configuration access is a write |
| cfg_wdata_o | output | ADDR_W | Window value to write |
| cfg_ack_i | input | 1 | Configuration access done |
| cfg_err_i | input | 1 | Configuration access failed (with ack) |
| cfg_rdata_i | input | ADDR_W | Window register readback (with ack) |
| mem_req_o | output | 1 | Memory access request through the window |
| mem_we_o | output | 1 | Memory access is a write |
| mem_size_o | output | 2 | Memory access size code |
| mem_offset_o | output | OFF_W | Memory access offset |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory access done |
| mem_rdata_i | input | 32 | Memory read data (with ack) |

## Verification
Assertions check every cycle that:
- configuration and memory requests stay stable until acknowledged;
- the attempt counter never passes its bound and the retry timer ends in a single pulse;
- a configuration error ends the switch on the next cycle;
- a memory access only ever targets the recorded mapped core, never while the window is being moved;
- every error response carries all-ones at its size;
- a failed switch leaves no mapping behind.

The bench scenarios are needed for the rest:
- the exact window value and the decode of a faulty readback;
- the number of attempts and the spacing between them;
- skipping the switch on a hit;
- the absence of memory traffic after a failed write;
- a request issued while busy being ignored.

// File: rtl/cwin_pkg.sv
package cwin_pkg;
  typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2} acc_size_e;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cwin_codec.sv
module cwin_codec #(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned CORE_W       = 4,
  parameter int unsigned REGION_SHIFT = 12,
  parameter logic [ADDR_W-1:0] ENUM_BASE = 32'h1800_0000,
  localparam int unsigned IDX_W       = ADDR_W - REGION_SHIFT
) (
  input  logic [CORE_W-1:0] core_i,
  output logic [ADDR_W-1:0] win_o,
  input  logic [ADDR_W-1:0] win_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0] rel;

  // power-of-two region: shift instead of divide
  assign win_o = ENUM_BASE + (ADDR_W'(core_i) << REGION_SHIFT);
  assign rel   = win_i - ENUM_BASE;
  assign idx_o = rel[ADDR_W-1:REGION_SHIFT];
endmodule

// File: rtl/cwin_delay.sv
module cwin_delay #(
  parameter int unsigned CYCLES = 1000,
  localparam int unsigned CW    = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (active_q) begin
        if (cnt_q == CW'(CYCLES - 1)) begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_single_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/cwin_switch.sv
module cwin_switch #(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned CORE_W       = 4,
  parameter int unsigned REGION_SHIFT = 12,
  parameter logic [ADDR_W-1:0] ENUM_BASE = 32'h1800_0000,
  parameter int unsigned MAX_RETRIES  = 3,
  parameter int unsigned WAIT_CYC     = 1000,
  localparam int unsigned IDX_W       = ADDR_W - REGION_SHIFT,
  localparam int unsigned ATT_W       = $clog2(MAX_RETRIES + 2) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CORE_W-1:0] core_i,
  output logic              done_o,
  output logic              ok_o,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [ADDR_W-1:0] cfg_wdata_o,
  input  logic              cfg_ack_i,
  input  logic              cfg_err_i,
  input  logic [ADDR_W-1:0] cfg_rdata_i
);
  typedef enum logic [1:0] {SW_IDLE, SW_WR, SW_RD, SW_WAIT} sw_st_e;

  sw_st_e            st_q;
  logic [CORE_W-1:0] core_q;
  logic [ATT_W-1:0]  att_q;
  logic [IDX_W-1:0]  rd_idx;
  logic              wait_load, wait_done, match;

  cwin_codec #(
    .ADDR_W(ADDR_W), .CORE_W(CORE_W), .REGION_SHIFT(REGION_SHIFT), .ENUM_BASE(ENUM_BASE)
  ) i_codec (
    .core_i(core_q), .win_o(cfg_wdata_o), .win_i(cfg_rdata_i), .idx_o(rd_idx)
  );

  cwin_delay #(.CYCLES(WAIT_CYC)) i_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wait_load), .done_o(wait_done)
  );

  assign cfg_req_o = (st_q == SW_WR) || (st_q == SW_RD);
  assign cfg_we_o  = (st_q == SW_WR);
  assign match     = (rd_idx == IDX_W'(core_q));
  assign wait_load = (st_q == SW_RD) && cfg_ack_i && !cfg_err_i && !match &&
                     !(att_q > ATT_W'(MAX_RETRIES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SW_IDLE;
      core_q <= '0;
      att_q  <= '0;
      done_o <= 1'b0;
      ok_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        SW_IDLE: if (start_i) begin
          core_q <= core_i;
          att_q  <= '0;
          st_q   <= SW_WR;
        end
        SW_WR: if (cfg_ack_i) begin
          if (cfg_err_i) begin
            done_o <= 1'b1;
            ok_o   <= 1'b0;
            st_q   <= SW_IDLE;
          end else begin
            st_q <= SW_RD;
          end
        end
        SW_RD: if (cfg_ack_i) begin
          if (cfg_err_i || match || (att_q > ATT_W'(MAX_RETRIES))) begin
            done_o <= 1'b1;
            ok_o   <= !cfg_err_i && match;
            st_q   <= SW_IDLE;
          end else begin
            att_q <= att_q + 1'b1;
            st_q  <= SW_WAIT;
          end
        end
        SW_WAIT: if (wait_done) st_q <= SW_WR;
        default: st_q <= SW_IDLE;
      endcase
    end
  end

  p_cfg_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_ack_i |=> cfg_req_o && $stable(cfg_we_o) && $stable(cfg_wdata_o));
  p_att_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_q <= ATT_W'(MAX_RETRIES + 1));
  p_err_abort_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_ack_i && cfg_err_i |=> done_o && !ok_o && !cfg_req_o);
endmodule

// File: rtl/core_window_ctrl.sv
module core_window_ctrl
  import cwin_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned CORE_W       = 4,
  parameter int unsigned OFF_W        = 12,
  parameter int unsigned REGION_SHIFT = 12,
  parameter logic [ADDR_W-1:0] ENUM_BASE = 32'h1800_0000,
  parameter int unsigned MAX_RETRIES  = 3,
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned WAIT_US      = 10,
  localparam int unsigned WAIT_CYC    = CLK_MHZ * WAIT_US
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic [OFF_W-1:0]  req_offset_i,
  input  logic [31:0]       req_wdata_i,
  output logic              busy_o,
  output logic              resp_done_o,
  output logic              resp_err_o,
  output logic [31:0]       resp_rdata_o,
  output logic              mapped_valid_o,
  output logic [CORE_W-1:0] mapped_core_o,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [ADDR_W-1:0] cfg_wdata_o,
  input  logic              cfg_ack_i,
  input  logic              cfg_err_i,
  input  logic [ADDR_W-1:0] cfg_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_size_o,
  output logic [OFF_W-1:0]  mem_offset_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  typedef enum logic [1:0] {T_IDLE, T_SWITCH, T_ACCESS, T_RESP} top_st_e;

  top_st_e           st_q;
  logic [CORE_W-1:0] core_q;
  logic              hit, sw_start, sw_done, sw_ok;

  assign hit      = mapped_valid_o && (mapped_core_o == req_core_i);
  assign sw_start = (st_q == T_IDLE) && req_valid_i && !hit;

  cwin_switch #(
    .ADDR_W(ADDR_W), .CORE_W(CORE_W), .REGION_SHIFT(REGION_SHIFT), .ENUM_BASE(ENUM_BASE),
    .MAX_RETRIES(MAX_RETRIES), .WAIT_CYC(WAIT_CYC)
  ) i_switch (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(sw_start), .core_i(req_core_i),
    .done_o(sw_done), .ok_o(sw_ok),
    .cfg_req_o(cfg_req_o), .cfg_we_o(cfg_we_o), .cfg_wdata_o(cfg_wdata_o),
    .cfg_ack_i(cfg_ack_i), .cfg_err_i(cfg_err_i), .cfg_rdata_i(cfg_rdata_i)
  );

  assign busy_o      = (st_q != T_IDLE);
  assign resp_done_o = (st_q == T_RESP);
  assign mem_req_o   = (st_q == T_ACCESS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= T_IDLE;
      core_q         <= '0;
      mem_we_o       <= 1'b0;
      mem_size_o     <= 2'd0;
      mem_offset_o   <= '0;
      mem_wdata_o    <= '0;
      mapped_valid_o <= 1'b0;
      mapped_core_o  <= '0;
      resp_err_o     <= 1'b0;
      resp_rdata_o   <= '0;
    end else begin
      case (st_q)
        T_IDLE: if (req_valid_i) begin
          core_q       <= req_core_i;
          mem_we_o     <= req_write_i;
          mem_size_o   <= req_size_i;
          mem_offset_o <= req_offset_i;
          mem_wdata_o  <= req_wdata_i;
          st_q         <= hit ? T_ACCESS : T_SWITCH;
        end
        T_SWITCH: if (sw_done) begin
          if (sw_ok) begin
            mapped_valid_o <= 1'b1;
            mapped_core_o  <= core_q;
            st_q           <= T_ACCESS;
          end else begin
            // window contents unknown after a failed switch
            mapped_valid_o <= 1'b0;
            resp_err_o     <= 1'b1;
            resp_rdata_o   <= size_mask(mem_size_o);
            st_q           <= T_RESP;
          end
        end
        T_ACCESS: if (mem_ack_i) begin
          resp_err_o   <= 1'b0;
          resp_rdata_o <= mem_we_o ? 32'h0 : (mem_rdata_i & size_mask(mem_size_o));
          st_q         <= T_RESP;
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  p_access_mapped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mapped_valid_o && (mapped_core_o == core_q) && !cfg_req_o);
  p_mem_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_offset_o));
  p_fail_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_done_o && resp_err_o |-> resp_rdata_o == size_mask(mem_size_o));
  p_fail_unmap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_done && !sw_ok |=> !mapped_valid_o);
  p_switch_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> busy_o && !resp_done_o);
endmodule

// File: tb/test_core_window_ctrl.sv
module test_core_window_ctrl;
  localparam int unsigned CORE_W = 4, OFF_W = 12, SHIFT = 12, MAXR = 3, WCYC = 1000;
  localparam logic [31:0] BASE = 32'h1800_0000;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic              req_valid = 0, req_write = 0;
  logic [CORE_W-1:0] req_core = '0;
  logic [1:0]        req_size = '0;
  logic [OFF_W-1:0]  req_off = '0;
  logic [31:0]       req_wdata = '0;
  logic busy, resp_done, resp_err, mapped_valid;
  logic [31:0] resp_rdata;
  logic [CORE_W-1:0] mapped_core;
  logic cfg_req, cfg_we, cfg_ack = 0, cfg_err = 0;
  logic [31:0] cfg_wdata, cfg_rdata = '0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [1:0] mem_size;
  logic [OFF_W-1:0] mem_off;
  logic [31:0] mem_wdata, mem_rdata = '0;

  core_window_ctrl i_core_window_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_core_i(req_core), .req_write_i(req_write),
    .req_size_i(req_size), .req_offset_i(req_off), .req_wdata_i(req_wdata),
    .busy_o(busy), .resp_done_o(resp_done), .resp_err_o(resp_err), .resp_rdata_o(resp_rdata),
    .mapped_valid_o(mapped_valid), .mapped_core_o(mapped_core),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_wdata_o(cfg_wdata),
    .cfg_ack_i(cfg_ack), .cfg_err_i(cfg_err), .cfg_rdata_i(cfg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_size_o(mem_size), .mem_offset_o(mem_off),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  // config model: 0 normal, 1 always mismatch, 2 mismatch for mis_left reads, 3 write error, 4 read error
  int cfg_mode = 0, mis_left = 0;
  int n_wr = 0, n_rd = 0, last_wr_cyc = 0, gap = 0;
  logic [31:0] win = '0, last_wval = '0;
  int n_mrd = 0, n_mwr = 0;
  logic [31:0] last_mwdata = '0;
  logic [OFF_W-1:0] last_moff = '0;
  logic got = 0, got_err = 0;
  logic [31:0] got_data = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    cfg_ack <= cfg_req && !cfg_ack;
    cfg_err <= 1'b0;
    if (cfg_req && !cfg_ack) begin
      if (cfg_we) begin
        n_wr <= n_wr + 1;
        gap <= cyc - last_wr_cyc;
        last_wr_cyc <= cyc;
        last_wval <= cfg_wdata;
        if (cfg_mode == 3) cfg_err <= 1'b1;
        else win <= cfg_wdata;
      end else begin
        n_rd <= n_rd + 1;
        cfg_rdata <= win;
        if (cfg_mode == 4) cfg_err <= 1'b1;
        else if (cfg_mode == 1) cfg_rdata <= win + (32'h1 << SHIFT);
        else if (cfg_mode == 2 && mis_left > 0) begin
          cfg_rdata <= win + (32'h1 << SHIFT);
          mis_left <= mis_left - 1;
        end
      end
    end
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      mem_rdata <= 32'hC3A5_0000 | 32'(mem_off);
      if (mem_we) begin
        n_mwr <= n_mwr + 1;
        last_mwdata <= mem_wdata;
        last_moff <= mem_off;
      end else n_mrd <= n_mrd + 1;
    end
    if (resp_done) begin
      got <= 1'b1;
      got_err <= resp_err;
      got_data <= resp_rdata;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [CORE_W-1:0] c, input logic w, input logic [1:0] sz,
                        input logic [OFF_W-1:0] off, input logic [31:0] d);
    int t = 0;
    @(negedge clk);
    got = 0;
    req_valid = 1; req_core = c; req_write = w; req_size = sz; req_off = off; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    while (!got && t < 20000) begin @(negedge clk); t++; end
    if (!got) chk(1'b0, "timeout", 0, 1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!busy && !mapped_valid && !cfg_req && !mem_req, "R9 reset state",
        {mapped_valid, busy, cfg_req, mem_req}, 0);
  endtask

  task automatic t_first_switch;
    int w0 = n_wr, r0 = n_rd;
    access(4'd2, 0, 2'd2, 12'h040, 0);
    chk(n_wr == w0 + 1, "R1 one window write", n_wr - w0, 1);
    chk(last_wval == BASE + (32'd2 << SHIFT), "R1 window value", last_wval, BASE + (32'd2 << SHIFT));
    chk(n_rd == r0 + 1, "R2 one readback", n_rd - r0, 1);
    chk(!got_err && got_data == 32'hC3A5_0040, "R6 32-bit read", got_data, 32'hC3A5_0040);
    chk(mapped_valid && mapped_core == 4'd2, "R5 mapped core", mapped_core, 2);
  endtask

  task automatic t_hit;
    int w0 = n_wr;
    access(4'd2, 0, 2'd1, 12'h0AB, 0);
    chk(n_wr == w0, "R5 hit skips switch", n_wr - w0, 0);
    chk(got_data == 32'h0000_00AB, "R6 16-bit read masked", got_data, 32'h0000_00AB);
    access(4'd2, 1, 2'd2, 12'h123, 32'hDEAD_BEEF);
    chk(last_mwdata == 32'hDEAD_BEEF && last_moff == 12'h123, "R6 write forwarded", last_mwdata, 32'hDEAD_BEEF);
    chk(!got_err && got_data == 0, "R6 write response", got_data, 0);
  endtask

  task automatic t_transient;
    int w0 = n_wr;
    cfg_mode = 2; mis_left = 2;
    access(4'd5, 0, 2'd0, 12'h0C7, 0);
    cfg_mode = 0;
    chk(n_wr == w0 + 3, "R3 retries until match", n_wr - w0, 3);
    chk(gap >= WCYC && gap <= WCYC + 8, "R3 retry spacing", gap, WCYC);
    chk(!got_err && got_data == 32'hC7, "R2 match after retry", got_data, 32'hC7);
    chk(mapped_core == 4'd5, "R5 mapped after retry", mapped_core, 5);
  endtask

  task automatic t_hard_mismatch;
    int w0 = n_wr, r0 = n_rd, m0 = n_mrd;
    cfg_mode = 1;
    access(4'd7, 0, 2'd0, 12'h010, 0);
    cfg_mode = 0;
    chk(n_wr == w0 + MAXR + 2 && n_rd == r0 + MAXR + 2, "R3 attempt limit", n_wr - w0, MAXR + 2);
    chk(got_err && got_data == 32'hFF, "R7 8-bit all-ones", got_data, 32'hFF);
    chk(n_mrd == m0, "R7 no memory read", n_mrd - m0, 0);
    chk(!mapped_valid, "R10 mapping cleared", mapped_valid, 0);
  endtask

  task automatic t_cfg_err;
    int w0 = n_wr, r0 = n_rd, m0 = n_mwr;
    cfg_mode = 3;
    access(4'd3, 0, 2'd1, 12'h0, 0);
    chk(n_wr == w0 + 1 && n_rd == r0, "R4 write error aborts", n_rd - r0, 0);
    chk(got_err && got_data == 32'hFFFF, "R7 16-bit all-ones", got_data, 32'hFFFF);
    cfg_mode = 4; w0 = n_wr;
    access(4'd3, 0, 2'd2, 12'h0, 0);
    chk(n_wr == w0 + 1, "R4 read error aborts", n_wr - w0, 1);
    chk(got_err && got_data == 32'hFFFF_FFFF, "R7 32-bit all-ones", got_data, 32'hFFFF_FFFF);
    access(4'd3, 1, 2'd2, 12'h0, 32'h1234_5678);
    chk(got_err && n_mwr == m0, "R7 failed write dropped", n_mwr - m0, 0);
    cfg_mode = 0; w0 = n_wr;
    access(4'd3, 0, 2'd2, 12'h004, 0);
    chk(n_wr == w0 + 1 && !got_err, "R10 switch again after failure", n_wr - w0, 1);
  endtask

  task automatic t_busy;
    int m0 = n_mwr, t = 0;
    @(negedge clk);
    got = 0;
    req_valid = 1; req_core = 4'd4; req_write = 1; req_size = 2'd2; req_off = 12'h008; req_wdata = 32'hAAAA_0001;
    @(negedge clk);
    chk(busy, "R8 busy after accept", busy, 1);
    req_core = 4'd9; req_wdata = 32'hBBBB_0002;
    @(negedge clk);
    req_valid = 0;
    while (!got && t < 20000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(n_mwr == m0 + 1 && last_mwdata == 32'hAAAA_0001, "R8 request while busy ignored", last_mwdata, 32'hAAAA_0001);
    chk(!busy && mapped_core == 4'd4, "R8 idle after response", mapped_core, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_first_switch();
    t_hit();
    t_transient();
    t_hard_mismatch();
    t_cfg_err();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule